// File: doc/BRIEF.md
# Systolic Sequence Alignment Chain

This block scores a short query string against a stream of database strings using the dynamic-programming alignment recurrence. It is built as a one-dimensional chain of processing elements, and each element owns one query symbol. One symbol channel, tagged valid, query-or-data and end-of-string, serves two purposes. First it carries the query, which spreads itself along the chain. After that it carries database strings, one symbol per clock cycle. Each database symbol walks down the chain together with a running score, so that each element fills one matrix cell per symbol.

Elements are grouped into clusters of `CLUSTER` elements. A cluster has one small controller that decides which element latches a query symbol and when a new string starts. Inside a cluster, scores and symbols pass straight from element to element. A single register stage sits only between clusters. The last cluster delivers the score of the bottom matrix row for every database symbol. The score for the final symbol of a string carries a marker and is the alignment score. A new database string may follow on the very next cycle.

Top module: `align_chain`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `out_valid` and `out_last` are low.
- R2: A query load is exactly `NUM_PE` symbols presented with `in_query`=1, and `in_last`=1 on the final symbol. The i-th symbol presented ends up in element i, counting from the chain input.
- R3: For query symbol x_i and database symbol y_j, each cell computes S(i,j) = max(S(i-1,j-1)+sub, S(i,j-1)-gap, S(i-1,j)-gap) in signed arithmetic. Here sub is +`MATCH` (2) when x_i equals y_j and -`MISMATCH` (-1) otherwise, and every boundary value S(0,j) and S(i,0) is 0.
- R4: Every database symbol accepted (`in_valid`=1, `in_query`=0) produces exactly one `out_valid` pulse carrying S(NUM_PE,j). That pulse appears NUM_PE/CLUSTER clock edges after the edge that sampled the symbol.
- R5: `out_last` is high exactly on the output produced by a database symbol sent with `in_last`=1, so `out_score` there is the final alignment score.
- R6: A database string may start on the cycle right after the previous one ended. Its first column uses the zero boundary and does not use the previous string's scores.
- R7: Cycles with `in_valid`=0 between database symbols are ignored: they change neither the scores of later symbols nor the output timing relative to each symbol.
- R8: Query symbols never produce `out_valid`.
- R9: A new query load replaces the previous query. It may follow the end of a database string on the next cycle, with no drain.
- R10: `gap_pen` is an unsigned penalty. It must be held stable from the first symbol of a database string until that string's final score appears, and different strings may use different penalties.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A symbol is present on the channel this cycle |
| in_query | input | 1 | 1: the symbol belongs to a query load, 0: it belongs to a database string |
| in_last | input | 1 | Final symbol of the current query or database string |
| in_char | input | CHAR_W | Symbol code |
| gap_pen | input | GAP_W | Unsigned gap penalty |
| out_valid | output | 1 | Bottom-row score for one database symbol |
| out_last | output | 1 | The score belongs to the final symbol of its string |
| out_score | output | SCORE_W | Signed score S(NUM_PE, j) |

## Verification
The hardest situation to produce at the ports is one where two strings, or a string and a fresh query, are present in the chain at the same time. One cluster then holds the new string's boundary state while its neighbour still finishes the old one. The bench packs strings back to back, sends one-symbol strings, and starts a query reload on the cycle right after a database string ends. Each bottom-row score is compared with a full matrix computed in the bench. The bench also runs every three-symbol string over the four-letter alphabet and sweeps the gap penalty between strings.

// File: rtl/align_pkg.sv
package align_pkg;

   // What a symbol on the shared channel means at one point of the chain
   typedef enum logic [1:0] {
      FLIT_IDLE  = 2'd0,
      FLIT_QUERY = 2'd1,
      FLIT_DATA  = 2'd2
   } flit_kind_e;

endpackage

// File: rtl/align_cell.sv
module align_cell #(
   parameter int CHAR_W   = 2,
   parameter int SCORE_W  = 14,
   parameter int GAP_W    = 4,
   parameter int MATCH    = 2,
   parameter int MISMATCH = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load_en,
   input  logic                      step,
   input  logic                      seq_first,
   input  logic [CHAR_W-1:0]         char_in,
   input  logic signed [SCORE_W-1:0] left_in,
   input  logic [GAP_W-1:0]          gap,
   output logic signed [SCORE_W-1:0] score_out
);

   localparam logic signed [SCORE_W-1:0] SUB_HIT  = SCORE_W'(MATCH);
   localparam logic signed [SCORE_W-1:0] SUB_MISS = SCORE_W'(-MISMATCH);

   logic [CHAR_W-1:0]         q_r;
   logic signed [SCORE_W-1:0] up_r;
   logic signed [SCORE_W-1:0] diag_r;

   logic signed [SCORE_W-1:0] gap_s;
   logic signed [SCORE_W-1:0] up_eff;
   logic signed [SCORE_W-1:0] diag_eff;
   logic signed [SCORE_W-1:0] cand_diag;
   logic signed [SCORE_W-1:0] cand_up;
   logic signed [SCORE_W-1:0] cand_left;
   logic signed [SCORE_W-1:0] best_a;

   always_comb begin
      gap_s     = $signed({{(SCORE_W-GAP_W){1'b0}}, gap});
      up_eff    = seq_first ? '0 : up_r;
      diag_eff  = seq_first ? '0 : diag_r;
      cand_diag = diag_eff + ((char_in == q_r) ? SUB_HIT : SUB_MISS);
      cand_up   = up_eff - gap_s;
      cand_left = left_in - gap_s;
      best_a    = (cand_diag >= cand_up) ? cand_diag : cand_up;
      score_out = (best_a >= cand_left) ? best_a : cand_left;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         up_r   <= '0;
         diag_r <= '0;
      end else begin
         if (load_en) begin
            q_r <= char_in;
         end
         if (step) begin
            up_r   <= score_out;
            diag_r <= left_in;
         end
      end
   end

endmodule

// File: rtl/align_ctrl.sv
module align_ctrl
   import align_pkg::*;
#(
   parameter int CLUSTER = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  flit_kind_e         kind,
   input  logic               last,
   output logic [CLUSTER-1:0] load_en,
   output logic               step,
   output logic               seq_first,
   output logic               fwd
);

   localparam int CNT_W = $clog2(CLUSTER + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(CLUSTER);

   logic [CNT_W-1:0] fill_r;
   logic             first_r;
   logic             has_room;

   assign has_room  = (fill_r != FULL);
   assign seq_first = first_r;

   always_comb begin
      for (int i = 0; i < CLUSTER; i++) begin
         load_en[i] = (kind == FLIT_QUERY) && (fill_r == CNT_W'(i));
      end
      step = (kind == FLIT_DATA);
      fwd  = (kind == FLIT_DATA) || ((kind == FLIT_QUERY) && !has_room);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_r  <= '0;
         first_r <= 1'b1;
      end else begin
         unique case (kind)
            FLIT_QUERY: begin
               first_r <= 1'b1;
               if (last)          fill_r <= '0;
               else if (has_room) fill_r <= fill_r + 1'b1;
            end
            FLIT_DATA: begin
               first_r <= last;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/align_cluster.sv
module align_cluster
   import align_pkg::*;
#(
   parameter int CLUSTER  = 2,
   parameter int CHAR_W   = 2,
   parameter int SCORE_W  = 14,
   parameter int GAP_W    = 4,
   parameter int MATCH    = 2,
   parameter int MISMATCH = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  flit_kind_e                in_kind,
   input  logic                      in_last,
   input  logic [CHAR_W-1:0]         in_char,
   input  logic signed [SCORE_W-1:0] in_score,
   input  logic [GAP_W-1:0]          gap,
   output flit_kind_e                out_kind,
   output logic                      out_last,
   output logic [CHAR_W-1:0]         out_char,
   output logic signed [SCORE_W-1:0] out_score
);

   logic [CLUSTER-1:0]        load_en;
   logic                      step;
   logic                      seq_first;
   logic                      fwd;
   logic signed [SCORE_W-1:0] link [CLUSTER+1];

   align_ctrl #(.CLUSTER(CLUSTER)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .kind      (in_kind),
      .last      (in_last),
      .load_en   (load_en),
      .step      (step),
      .seq_first (seq_first),
      .fwd       (fwd)
   );

   assign link[0] = in_score;

   for (genvar i = 0; i < CLUSTER; i++) begin : g_cell
      align_cell #(
         .CHAR_W   (CHAR_W),
         .SCORE_W  (SCORE_W),
         .GAP_W    (GAP_W),
         .MATCH    (MATCH),
         .MISMATCH (MISMATCH)
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_en   (load_en[i]),
         .step      (step),
         .seq_first (seq_first),
         .char_in   (in_char),
         .left_in   (link[i]),
         .gap       (gap),
         .score_out (link[i+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_kind  <= FLIT_IDLE;
         out_last  <= 1'b0;
         out_char  <= '0;
         out_score <= '0;
      end else begin
         out_kind  <= fwd ? in_kind : FLIT_IDLE;
         out_last  <= fwd && in_last;
         out_char  <= in_char;
         out_score <= (in_kind == FLIT_DATA) ? link[CLUSTER] : '0;
      end
   end

endmodule

// File: rtl/align_chain.sv
module align_chain
   import align_pkg::*;
#(
   parameter int NUM_PE   = 8,
   parameter int CLUSTER  = 2,
   parameter int CHAR_W   = 2,
   parameter int SCORE_W  = 14,
   parameter int GAP_W    = 4,
   parameter int MATCH    = 2,
   parameter int MISMATCH = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic                      in_query,
   input  logic                      in_last,
   input  logic [CHAR_W-1:0]         in_char,
   input  logic [GAP_W-1:0]          gap_pen,
   output logic                      out_valid,
   output logic                      out_last,
   output logic signed [SCORE_W-1:0] out_score
);

   localparam int N_CL = NUM_PE / CLUSTER;

   if (CLUSTER < 1 || (NUM_PE % CLUSTER) != 0) begin : g_bad_cluster
      $error("align_chain: NUM_PE must be a positive multiple of CLUSTER");
   end
   if (GAP_W >= SCORE_W) begin : g_bad_gap
      $error("align_chain: GAP_W must be narrower than SCORE_W");
   end
   if (CHAR_W < 1 || MATCH < 1 || MISMATCH < 0) begin : g_bad_cost
      $error("align_chain: symbol width and costs out of range");
   end

   flit_kind_e                kind_c  [N_CL+1];
   logic                      last_c  [N_CL+1];
   logic [CHAR_W-1:0]         char_c  [N_CL+1];
   logic signed [SCORE_W-1:0] score_c [N_CL+1];

   assign kind_c[0]  = !in_valid ? FLIT_IDLE : (in_query ? FLIT_QUERY : FLIT_DATA);
   assign last_c[0]  = in_last;
   assign char_c[0]  = in_char;
   assign score_c[0] = '0;

   for (genvar c = 0; c < N_CL; c++) begin : g_cluster
      align_cluster #(
         .CLUSTER  (CLUSTER),
         .CHAR_W   (CHAR_W),
         .SCORE_W  (SCORE_W),
         .GAP_W    (GAP_W),
         .MATCH    (MATCH),
         .MISMATCH (MISMATCH)
      ) u_cluster (
         .clk       (clk),
         .rst_n     (rst_n),
         .in_kind   (kind_c[c]),
         .in_last   (last_c[c]),
         .in_char   (char_c[c]),
         .in_score  (score_c[c]),
         .gap       (gap_pen),
         .out_kind  (kind_c[c+1]),
         .out_last  (last_c[c+1]),
         .out_char  (char_c[c+1]),
         .out_score (score_c[c+1])
      );
   end

   assign out_valid = (kind_c[N_CL] == FLIT_DATA);
   assign out_last  = out_valid && last_c[N_CL];
   assign out_score = score_c[N_CL];

endmodule

// File: rtl/align_chain_chk.sv
module align_chain_chk #(
   parameter int NUM_PE  = 8,
   parameter int CLUSTER = 2,
   parameter int SCORE_W = 14,
   parameter int MATCH   = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic                      in_query,
   input logic                      in_last,
   input logic                      out_valid,
   input logic                      out_last,
   input logic signed [SCORE_W-1:0] out_score
);

   localparam int N_CL = NUM_PE / CLUSTER;

   logic [15:0] inflight;
   logic [15:0] pend_last;
   logic        data_in;

   assign data_in = in_valid && !in_query;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight  <= '0;
         pend_last <= '0;
      end else begin
         inflight  <= inflight + 16'(data_in) - 16'(out_valid);
         pend_last <= pend_last + 16'(data_in && in_last) - 16'(out_last);
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> !out_valid && !out_last); // R1

   AST_OUT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> inflight != 16'd0); // R4

   AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= 16'(N_CL)); // R4

   AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid); // R5

   AST_LAST_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> pend_last != 16'd0); // R5

   AST_SCORE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $signed(out_score) <= MATCH * NUM_PE); // R3

endmodule

bind align_chain align_chain_chk #(
   .NUM_PE  (NUM_PE),
   .CLUSTER (CLUSTER),
   .SCORE_W (SCORE_W),
   .MATCH   (MATCH)
) u_align_chain_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_query  (in_query),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_last  (out_last),
   .out_score (out_score)
);

// File: tb/test_align_chain.sv
`timescale 1ns/1ps
module test_align_chain;

   localparam int NP      = 8;
   localparam int CL      = 2;
   localparam int N_CL    = NP / CL;
   localparam int CHAR_W  = 2;
   localparam int SCORE_W = 14;
   localparam int GAP_W   = 4;
   localparam int QDEPTH  = 1024;

   logic                      clk = 1'b0;
   logic                      rst_n = 1'b0;
   logic                      in_valid = 1'b0;
   logic                      in_query = 1'b0;
   logic                      in_last = 1'b0;
   logic [CHAR_W-1:0]         in_char = '0;
   logic [GAP_W-1:0]          gap_pen = '0;
   logic                      out_valid;
   logic                      out_last;
   logic signed [SCORE_W-1:0] out_score;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int rng    = 32'h1234_5678;
   string tag = "R2";

   int qry [NP];
   int dbs [64];
   int col [64];
   int exp_score [QDEPTH];
   int exp_last  [QDEPTH];
   int exp_cyc   [QDEPTH];
   int wr = 0;
   int rd = 0;

   align_chain #(
      .NUM_PE(NP), .CLUSTER(CL), .CHAR_W(CHAR_W),
      .SCORE_W(SCORE_W), .GAP_W(GAP_W)
   ) i_align_chain (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_query(in_query),
      .in_last(in_last), .in_char(in_char), .gap_pen(gap_pen),
      .out_valid(out_valid), .out_last(out_last), .out_score(out_score)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int rnd(input int lim);
      rng = rng * 1103515245 + 12345;
      return ((rng >>> 8) & 32'h7fff) % lim;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   // Full matrix with zero boundaries; fills col[0..len-1] with bottom row
   task automatic model(input int len, input int g);
      int up [NP+1];
      for (int k = 0; k <= NP; k++) up[k] = 0;
      for (int j = 0; j < len; j++) begin
         int diag = 0;
         int left = 0;
         for (int k = 1; k <= NP; k++) begin
            int cur = diag + ((qry[k-1] == dbs[j]) ? 2 : -1);
            if (up[k] - g > cur) cur = up[k] - g;
            if (left - g > cur)  cur = left - g;
            diag  = up[k];
            up[k] = cur;
            left  = cur;
         end
         col[j] = up[NP];
      end
   endtask

   task automatic idle(input int n, input bit quiet_chk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_last = 1'b0; in_query = 1'b0;
         if (quiet_chk) check(out_valid == 1'b0, "R8", int'(out_valid), 0);
      end
   endtask

   task automatic send_query(input bit quiet_chk);
      for (int k = 0; k < NP; k++) begin
         @(negedge clk);
         if (quiet_chk) check(out_valid == 1'b0, "R8", int'(out_valid), 0);
         in_valid = 1'b1; in_query = 1'b1;
         in_char  = CHAR_W'(qry[k]);
         in_last  = (k == NP - 1);
      end
   endtask

   task automatic send_db(input int len, input int g, input bit bubbles);
      model(len, g);
      for (int j = 0; j < len; j++) begin
         @(negedge clk);
         gap_pen  = GAP_W'(g);
         in_valid = 1'b1; in_query = 1'b0;
         in_char  = CHAR_W'(dbs[j]);
         in_last  = (j == len - 1);
         exp_score[wr % QDEPTH] = col[j];
         exp_last[wr % QDEPTH]  = (j == len - 1);
         exp_cyc[wr % QDEPTH]   = cyc + N_CL;
         wr++;
         if (bubbles && rnd(2) == 1) begin
            @(negedge clk);
            in_valid = 1'b0; in_last = 1'b0;
         end
      end
   endtask

   // Output monitor: compares every score against the bench's matrix
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (rd == wr) begin
            check(1'b0, "R8", 1, 0);
         end else begin
            check(int'(out_score) == exp_score[rd % QDEPTH], tag,
                  int'(out_score), exp_score[rd % QDEPTH]);
            check(int'(out_last) == exp_last[rd % QDEPTH], "R5",
                  int'(out_last), exp_last[rd % QDEPTH]);
            check(cyc == exp_cyc[rd % QDEPTH], "R4", cyc, exp_cyc[rd % QDEPTH]);
            rd++;
         end
      end else if (rst_n && out_last) begin
         check(1'b0, "R5", 1, 0);
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);
      check(out_last == 1'b0, "R1", int'(out_last), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", int'(out_valid), 0);

      // R2: load a structured query, then match it against itself
      tag = "R2";
      for (int k = 0; k < NP; k++) qry[k] = k % 4;
      send_query(1'b1);
      idle(N_CL + 2, 1'b1);
      for (int j = 0; j < NP; j++) dbs[j] = qry[j];
      send_db(NP, 1, 1'b0);
      for (int j = 0; j < NP; j++) dbs[j] = qry[NP-1-j];
      send_db(NP, 1, 1'b0);
      idle(N_CL + 2, 1'b0);

      // R3: every three-symbol string, back to back
      tag = "R3";
      for (int s = 0; s < 64; s++) begin
         dbs[0] = s % 4; dbs[1] = (s / 4) % 4; dbs[2] = s / 16;
         send_db(3, 1, 1'b0);
      end
      idle(N_CL + 2, 1'b0);

      // R10: penalty sweep, drained between penalties
      tag = "R10";
      for (int g = 0; g < 16; g += 3) begin
         for (int r = 0; r < 4; r++) begin
            int len = 1 + rnd(12);
            for (int j = 0; j < len; j++) dbs[j] = rnd(4);
            send_db(len, g, 1'b0);
         end
         idle(N_CL + 2, 1'b0);
      end

      // R6: single-symbol strings back to back
      tag = "R6";
      for (int r = 0; r < 12; r++) begin
         dbs[0] = r % 4;
         send_db(1, 2, 1'b0);
      end
      idle(N_CL + 2, 1'b0);

      // R7: random bubbles between symbols
      tag = "R7";
      for (int r = 0; r < 10; r++) begin
         int len = 2 + rnd(14);
         for (int j = 0; j < len; j++) dbs[j] = rnd(4);
         send_db(len, 1, 1'b1);
      end
      idle(N_CL + 2, 1'b0);

      // R9: reload right behind a string, several times
      tag = "R9";
      for (int r = 0; r < 6; r++) begin
         int len = 4 + rnd(20);
         for (int j = 0; j < len; j++) dbs[j] = rnd(4);
         send_db(len, 1, 1'b0);
         for (int k = 0; k < NP; k++) qry[k] = rnd(4);
         send_query(1'b0);
         len = 1 + rnd(20);
         for (int j = 0; j < len; j++) dbs[j] = rnd(4);
         send_db(len, 1, 1'b0);
      end
      idle(N_CL + 4, 1'b0);
      check(rd == wr, "R4", rd, wr);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d outputs", rd, wr);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule